// File: doc/BRIEF.md
# Eight-Pin Port Interrupt Detector

This block turns the eight input pins of a general-purpose I/O port into one port interrupt. A two-flop synchronizer samples each pin. A third flop keeps the previous sample, so that each pin can be checked for a level or an edge event. Three control bits per pin choose the trigger: level mode, any-edge mode and active polarity. Together they give low-level, high-level, falling-edge, rising-edge or any-edge triggering.

Edge events are held in a sticky status bit until software clears that bit by writing a one to it. A level-mode status bit instead follows the pin for as long as the pin stays at its active level. A per-pin enable gates the status bits. The gated bits are OR-ed together and registered to form the interrupt line. Software configures the block, reads the status and acknowledges events through a small 3-bit-address register port. Reads are combinational.

Top module: `pin_irq_unit`

## Requirements
- R1: After reset, every control register, the enable register and all status bits read 0, and `irq_out` is 0. In this state every pin is falling-edge triggered and blocked.
- R2: A pin with its level-mode bit (address 0) set has a status bit that follows the synchronized pin. The bit is 1 while the pin equals the pin's polarity bit (address 2; 0 means low is active, 1 means high is active). A clear write has no effect on it.
- R3: A pin with both its level-mode bit and its any-edge bit (address 1) at 0 latches its status on a falling edge when its polarity bit is 0, and on a rising edge when its polarity bit is 1.
- R4: A pin in edge mode with its any-edge bit set latches its status on both rising and falling edges, whatever the value of its polarity bit.
- R5: A latched edge status stays at 1 until a write to the clear address (6) has a 1 in that pin's bit. Bits written as 0 leave their status unchanged.
- R6: An edge detected in the same cycle as a clear write to that pin leaves the status set.
- R7: The masked status (address 5) reads as the raw status (address 4) AND the enable register (address 3). A 0 in the enable register keeps that pin away from `irq_out`.
- R8: `irq_out` is a register that holds the OR of the masked status bits. It goes high one clock after the raw status bit sets. The raw status bit sets on the third rising clock edge after the pin changes.
- R9: A write to address 0, 1 or 2 that changes a pin's bit clears that pin's status bit.
- R10: The addresses are: level-mode 0, any-edge 1, polarity 2, enable 3, raw status 4, masked status 5, clear 6. Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_in | input | 8 | Asynchronous pin inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data, one bit per pin |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_out | output | 1 | Registered port interrupt |

## Verification
Two events can fall in the same cycle: an edge that sets a pin's status, and a software clear of that same bit. The bench makes them meet by counting clock edges from the pin change. It places the clear strobe exactly on the third edge, where the status register takes in the new edge. The raw status must then still read 1. A lone clear in another cycle serves as the control case and must drop the bit. A second timing check reads the raw status and `irq_out` on successive cycles after an event. This confirms the single register stage between them.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_LEVEL  = 3'd0,
    A_ANY    = 3'd1,
    A_POL    = 3'd2,
    A_ENABLE = 3'd3,
    A_RAW    = 3'd4,
    A_MASKED = 3'd5,
    A_CLEAR  = 3'd6,
    A_SPARE  = 3'd7
  } reg_addr_e;

  // Level trigger: active when the sample equals the chosen polarity.
  function automatic logic level_active(input logic pol, input logic cur);
    return cur == pol;
  endfunction

  // Edge trigger from two successive samples.
  function automatic logic edge_seen(input logic any, input logic pol,
                                     input logic cur, input logic prv);
    logic rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    if (any) return rise | fall;
    return pol ? rise : fall;
  endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] cur_q,
  output logic [WIDTH-1:0] prv_q
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= async_in;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  output logic [NPINS-1:0]  level_q,
  output logic [NPINS-1:0]  any_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  enable_q,
  output logic [NPINS-1:0]  cfg_changed,
  output logic [NPINS-1:0]  clr_strobe
);

  logic hit_level, hit_any, hit_pol, hit_en, hit_clr;

  always_comb begin
    hit_level = wr_en && (addr == A_LEVEL);
    hit_any   = wr_en && (addr == A_ANY);
    hit_pol   = wr_en && (addr == A_POL);
    hit_en    = wr_en && (addr == A_ENABLE);
    hit_clr   = wr_en && (addr == A_CLEAR);
    cfg_changed = (hit_level ? (wdata ^ level_q) : '0)
                | (hit_any   ? (wdata ^ any_q)   : '0)
                | (hit_pol   ? (wdata ^ pol_q)   : '0);
    clr_strobe  = hit_clr ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= '0;
      any_q    <= '0;
      pol_q    <= '0;
      enable_q <= '0;
    end else begin
      if (hit_level) level_q  <= wdata;
      if (hit_any)   any_q    <= wdata;
      if (hit_pol)   pol_q    <= wdata;
      if (hit_en)    enable_q <= wdata;
    end
  end

  // R10
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_ENABLE) |=> (enable_q == $past(wdata)));

  // R10
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_ENABLE) |=> $stable(enable_q));

endmodule

// File: rtl/pin_irq_cell.sv
module pin_irq_cell
  import pin_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_mode,
  input  logic any_edge,
  input  logic pol,
  input  logic cur,
  input  logic prv,
  input  logic clr,
  input  logic cfg_chg,
  output logic status_q
);

  logic edge_hit, lvl_hit;

  always_comb begin
    edge_hit = ~level_mode & edge_seen(any_edge, pol, cur, prv);
    lvl_hit  = level_mode & level_active(pol, cur);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          status_q <= 1'b0;
    else if (cfg_chg)    status_q <= 1'b0;
    else if (level_mode) status_q <= lvl_hit;
    else                 status_q <= edge_hit | (status_q & ~clr);
  end

  // R5
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && status_q && !clr && !cfg_chg) |=> status_q);

  // R6
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && clr && edge_hit && !cfg_chg) |=> status_q);

  // R9
  cfg_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> !status_q);

  // R2
  level_ignores_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && !cfg_chg && (cur == pol) && clr) |=> status_q);

  // R4
  any_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && any_edge && (cur != prv) && !cfg_chg) |=> status_q);

endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
  import pin_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [NPINS-1:0]  reg_wdata,
  output logic [NPINS-1:0]  reg_rdata,
  output logic              irq_out
);

  logic [NPINS-1:0] cur_w, prv_w;
  logic [NPINS-1:0] level_w, any_w, pol_w, enable_w;
  logic [NPINS-1:0] cfg_chg_w, clr_w;
  logic [NPINS-1:0] raw_w, masked_w;

  pin_irq_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pins_in),
    .cur_q(cur_w), .prv_q(prv_w)
  );

  pin_irq_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .level_q(level_w), .any_q(any_w), .pol_q(pol_w),
    .enable_q(enable_w), .cfg_changed(cfg_chg_w), .clr_strobe(clr_w)
  );

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    pin_irq_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .level_mode(level_w[g]), .any_edge(any_w[g]), .pol(pol_w[g]),
      .cur(cur_w[g]), .prv(prv_w[g]), .clr(clr_w[g]),
      .cfg_chg(cfg_chg_w[g]), .status_q(raw_w[g])
    );
  end

  assign masked_w = raw_w & enable_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |masked_w;
  end

  always_comb begin
    case (reg_addr_e'(reg_addr))
      A_LEVEL:  reg_rdata = level_w;
      A_ANY:    reg_rdata = any_w;
      A_POL:    reg_rdata = pol_w;
      A_ENABLE: reg_rdata = enable_w;
      A_RAW:    reg_rdata = raw_w;
      A_MASKED: reg_rdata = masked_w;
      default:  reg_rdata = '0;
    endcase
  end

  // R8
  irq_registered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(|(raw_w & enable_w))));

  // R7
  blocked_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_w == '0) |=> !irq_out);

endmodule

// File: tb/pin_irq_unit_bench.sv
`timescale 1ns/1ps
module pin_irq_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins_in = 8'h00;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq_out;

  int n_total = 0;
  int n_pass  = 0;

  // bench model
  logic [7:0] m_lvl = 0, m_any = 0, m_pol = 0, m_en = 0, m_lat = 0, m_pins = 0;

  always #2.5 clk = ~clk;

  pin_irq_unit u_pin_irq_unit (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [7:0] events_of(input logic [7:0] was, input logic [7:0] now,
                                           input logic [7:0] anyb, input logic [7:0] polb);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (anyb[i])      r[i] = was[i] ^ now[i];
      else if (polb[i]) r[i] = now[i] & ~was[i];
      else              r[i] = was[i] & ~now[i];
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_raw();
    return (m_lvl & ~(m_pins ^ m_pol)) | (~m_lvl & m_lat);
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_total++;
    if (got === exp) n_pass++;
    else $display("FAIL %s: got %h expected %h", tag, got, exp);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] ch;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    ch = 8'h00;
    case (a)
      3'd0: begin ch = d ^ m_lvl; m_lvl = d; end
      3'd1: begin ch = d ^ m_any; m_any = d; end
      3'd2: begin ch = d ^ m_pol; m_pol = d; end
      3'd3: m_en = d;
      3'd6: m_lat = m_lat & ~d;
      default: ;
    endcase
    m_lat = m_lat & ~ch;
    settle(4);
  endtask

  task automatic drive(input logic [7:0] v);
    @(negedge clk);
    m_lat = m_lat | (events_of(m_pins, v, m_any, m_pol) & ~m_lvl);
    pins_in = v; m_pins = v;
    settle(5);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    rd(3'd4, d); check({tag, " raw"}, d, exp_raw());
    rd(3'd5, d); check({tag, " masked"}, d, exp_raw() & m_en);
    check({tag, " irq"}, {7'd0, irq_out}, {7'd0, |(exp_raw() & m_en)});
  endtask

  initial begin
    #(200000 * 5);
    n_total++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd4242));
    settle(3);
    rst_n = 1'b1;
    settle(2);

    // R1 / R10 reset values and register map
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d); check($sformatf("R1 reset addr %0d", a), d, 8'h00);
    end
    check("R1 irq reset", {7'd0, irq_out}, 8'h00);

    // R3 falling edge default, blocked by enable (R7)
    drive(8'h02); drive(8'h00);
    rd(3'd4, d); check("R3 falling latched", d, 8'h02);
    check("R7 blocked irq", {7'd0, irq_out}, 8'h00);
    wr(3'd3, 8'h02);
    rd(3'd5, d); check("R7 masked read", d, 8'h02);
    check("R8 irq high", {7'd0, irq_out}, 8'h01);

    // R5 zero write keeps, one write clears
    wr(3'd6, 8'hFD); rd(3'd4, d); check("R5 zero bits keep", d, 8'h02);
    wr(3'd6, 8'h02); rd(3'd4, d); check("R5 clear", d, 8'h00);
    check("R5 irq dropped", {7'd0, irq_out}, 8'h00);

    // R3 rising edge with polarity 1
    wr(3'd2, 8'h04); drive(8'h04);
    rd(3'd4, d); check("R3 rising latched", d, 8'h04);
    wr(3'd6, 8'h04);

    // R4 any edge, polarity ignored
    wr(3'd1, 8'h08); drive(8'h0C);
    rd(3'd4, d); check("R4 rise", d, 8'h08);
    wr(3'd6, 8'h08); drive(8'h04);
    rd(3'd4, d); check("R4 fall", d, 8'h08);
    wr(3'd6, 8'h08);

    // R2 level high, clear ignored, follows pin
    wr(3'd2, 8'h14); wr(3'd0, 8'h10); drive(8'h14);
    rd(3'd4, d); check("R2 level high set", d, 8'h10);
    wr(3'd6, 8'h10); rd(3'd4, d); check("R2 clear ignored", d, 8'h10);
    drive(8'h04); rd(3'd4, d); check("R2 level drops", d, 8'h00);
    wr(3'd2, 8'h04); rd(3'd4, d); check("R2 level low active", d, 8'h10);
    wr(3'd0, 8'h00); check_all("R9 level to edge");

    // R9 config change clears latched edge
    drive(8'h24); drive(8'h04);
    rd(3'd4, d); check("R9 pre latch", d & 8'h20, 8'h20);
    wr(3'd2, 8'h24); rd(3'd4, d); check("R9 cleared by cfg", d & 8'h20, 8'h00);
    wr(3'd2, 8'h04);

    // R8 latency: raw on edge 3, irq on edge 4
    wr(3'd3, 8'h40);
    drive(8'h44);
    m_lat = m_lat | 8'h00;
    @(negedge clk); pins_in = 8'h04; m_pins = 8'h04; m_lat = m_lat | 8'h40;
    @(negedge clk); @(negedge clk); @(negedge clk);
    reg_addr = 3'd4; #0.5;
    check("R8 raw at edge 3", reg_rdata & 8'h40, 8'h40);
    check("R8 irq not yet", {7'd0, irq_out}, 8'h00);
    @(negedge clk);
    check("R8 irq at edge 4", {7'd0, irq_out}, 8'h01);
    settle(2);

    // R6 edge in same cycle as clear: pin6 already latched, new fall
    drive(8'h44);
    @(negedge clk); pins_in = 8'h04; m_pins = 8'h04;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h40;
    @(negedge clk); reg_wr = 1'b0;
    settle(3);
    rd(3'd4, d); check("R6 edge beats clear", d & 8'h40, 8'h40);
    wr(3'd6, 8'h40); rd(3'd4, d); check("R6 control clear", d & 8'h40, 8'h00);

    // random mix
    for (int it = 0; it < 60; it++) begin
      int act;
      act = $urandom_range(0, 5);
      case (act)
        0, 1: drive($urandom_range(0, 255));
        2: wr($urandom_range(0, 2), $urandom_range(0, 255));
        3: wr(3'd3, $urandom_range(0, 255));
        4: wr(3'd6, $urandom_range(0, 255));
        default: drive(m_pins ^ (8'h01 << $urandom_range(0, 7)));
      endcase
      check_all($sformatf("R7 R8 random %0d", it));
    end

    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

endmodule